// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the cartridge side of an 8-bit CPU system with a 16-bit address bus. The CPU cannot write to ROM. The controller therefore treats any CPU write into the lower half of the address space as a write to one of four small control registers. From those registers it builds the upper address lines for a banked ROM and a banked external RAM. It also decodes the chip selects for both memories.

The lowest 16 kB of CPU space always shows ROM bank 0. The next 16 kB is a window whose bank comes from the registers. An 8 kB region at 0xA000–0xBFFF opens onto external RAM. A one-bit mode register decides what a 2-bit secondary register does. In the default mode it supplies the top ROM bank bits. In the alternate mode it selects one of four RAM banks and also drives two general-purpose output pins.

All register loads happen on the clock edge at which a rising edge of the CPU write strobe is first seen, and only while the cartridge select is high. Reads leave the registers unchanged.

Top module: `cart_bank_ctrl`

## Requirements
- R1: For CPU addresses 0x0000–0x3FFF, `romAddr` equals the CPU address with all bank bits zero, whatever the register state.
- R2: For 0x4000–0x7FFF, `romAddr` is {highBits, primaryBank, cpuAddr[13:0]}. In mode 0, highBits is the 2-bit secondary register. In mode 1, highBits is zero.
- R3: A write to 0x2000–0x3FFF loads data bits [4:0] into the primary bank register. A value of 0 is stored as 1.
- R4: A write to 0x0000–0x1FFF enables RAM when data bits [3:0] are 0xA and disables it for any other value. `ramSel` is high only when RAM is enabled, `cartSel` is high and the address is in 0xA000–0xBFFF.
- R5: A write to 0x6000–0x7FFF loads data bit 0 as the mode. A write to 0x4000–0x5FFF loads data bits [1:0] into the secondary register.
- R6: In mode 1, `ramAddr` is {secondary, cpuAddr[12:0]} and `gpOut` equals the secondary register. In mode 0, `ramAddr` is {2'b00, cpuAddr[12:0]} and `gpOut` is 0.
- R7: `romSel` is high only for addresses below 0x8000 with `cartSel` high. Addresses from 0xFE00 up raise no select. Writes at or above 0x8000 change no register.
- R8: A register loads only on the first clock at which `wrStrobe` is seen high after being low, with `cartSel` high. Holding the strobe high, or writing with `cartSel` low, has no effect.
- R9: After reset the primary bank is 1, the secondary register is 0, RAM is disabled, the mode is 0 and `gpOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address bus |
| cpuDataIn | input | 8 | CPU write data |
| wrStrobe | input | 1 | CPU write strobe, active high |
| cartSel | input | 1 | Cartridge select, active high |
| romAddr | output | 21 | Physical ROM address |
| ramAddr | output | 15 | Physical RAM address |
| romSel | output | 1 | ROM chip select |
| ramSel | output | 1 | RAM chip select |
| gpOut | output | 2 | General-purpose output pins |

## Verification
The bench writes 0 and 0x20 to the primary bank register. A design that skips the zero fix-up would alias the switchable window onto bank 0 and give a wrong `romAddr`. It flips the mode in both directions while the secondary register is non-zero. A design that mixes up the two uses would leak RAM bank bits into the ROM address, or drive `gpOut` in mode 0. It also holds the strobe high while the data changes, and writes with `cartSel` low or above 0x7FFF. A level-sensitive or unqualified load would then corrupt the bank registers, and the next probe reveals it.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int PRIM_W    = 5;
  localparam int SEC_W     = 2;
  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;
  localparam int ROM_ADDR_W = SEC_W + PRIM_W + ROM_OFS_W;
  localparam int RAM_ADDR_W = SEC_W + RAM_OFS_W;
  localparam logic [3:0] RAM_KEY = 4'hA;

  // Region codes taken from cpuAddr[14:13] inside the lower 32 kB
  typedef enum logic [1:0] {
    REG_RAMEN = 2'b00,
    REG_PRIM  = 2'b01,
    REG_SEC   = 2'b10,
    REG_MODE  = 2'b11
  } regSel_e;

  typedef struct packed {
    logic              ldRamEn;
    logic              ldPrim;
    logic              ldSec;
    logic              ldMode;
    logic              ramEnVal;
    logic [PRIM_W-1:0] primVal;
    logic [SEC_W-1:0]  secVal;
    logic              modeVal;
  } bankStrobe_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cpuAddrHi,
  input  logic [DATA_W-1:0] cpuDataIn,
  input  logic              wrStrobe,
  input  logic              cartSel,
  output bankStrobe_t       stb
);
  logic wrPrev;
  logic wrEdge;
  logic anyLoad;
  logic unusedBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrStrobe;
  end

  // Only the lower 32 kB carries control registers
  assign wrEdge = wrStrobe & ~wrPrev & cartSel & ~cpuAddrHi[2];
  assign unusedBits = &{1'b0, cpuDataIn[DATA_W-1:PRIM_W]};

  always_comb begin
    stb          = '0;
    stb.ldRamEn  = wrEdge && (regSel_e'(cpuAddrHi[1:0]) == REG_RAMEN);
    stb.ldPrim   = wrEdge && (regSel_e'(cpuAddrHi[1:0]) == REG_PRIM);
    stb.ldSec    = wrEdge && (regSel_e'(cpuAddrHi[1:0]) == REG_SEC);
    stb.ldMode   = wrEdge && (regSel_e'(cpuAddrHi[1:0]) == REG_MODE);
    stb.ramEnVal = (cpuDataIn[3:0] == RAM_KEY);
    stb.primVal  = (cpuDataIn[PRIM_W-1:0] == '0) ? PRIM_W'(1) : cpuDataIn[PRIM_W-1:0];
    stb.secVal   = cpuDataIn[SEC_W-1:0];
    stb.modeVal  = cpuDataIn[0];
  end

  assign anyLoad = stb.ldRamEn | stb.ldPrim | stb.ldSec | stb.ldMode;

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldRamEn, stb.ldPrim, stb.ldSec, stb.ldMode})); // R5
  AST_NO_LOAD_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !cartSel |-> !anyLoad); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> !anyLoad); // R8
  AST_NO_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    cpuAddrHi[2] |-> !anyLoad); // R7
endmodule

// File: rtl/bank_dp.sv
module bank_dp
  import bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic                  cartSel,
  input  bankStrobe_t           stb,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  romSel,
  output logic                  ramSel,
  output logic [SEC_W-1:0]      gpOut
);
  logic [PRIM_W-1:0] primBank;
  logic [SEC_W-1:0]  secBank;
  logic              ramEn;
  logic              modeRam;
  logic [SEC_W-1:0]  romHi;
  logic [SEC_W-1:0]  ramBank;
  logic              inRamWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primBank <= PRIM_W'(1);
      secBank  <= '0;
      ramEn    <= 1'b0;
      modeRam  <= 1'b0;
    end else begin
      if (stb.ldPrim)  primBank <= stb.primVal;
      if (stb.ldSec)   secBank  <= stb.secVal;
      if (stb.ldRamEn) ramEn    <= stb.ramEnVal;
      if (stb.ldMode)  modeRam  <= stb.modeVal;
    end
  end

  assign romHi   = modeRam ? '0 : secBank;
  assign ramBank = modeRam ? secBank : '0;
  assign gpOut   = modeRam ? secBank : '0;

  always_comb begin
    if (cpuAddr[ROM_OFS_W])
      romAddr = {romHi, primBank, cpuAddr[ROM_OFS_W-1:0]};
    else
      romAddr = {{(SEC_W+PRIM_W){1'b0}}, cpuAddr[ROM_OFS_W-1:0]};
  end

  assign ramAddr  = {ramBank, cpuAddr[RAM_OFS_W-1:0]};
  assign inRamWin = (cpuAddr[ADDR_W-1:RAM_OFS_W] == 3'b101);
  assign romSel   = cartSel & ~cpuAddr[ADDR_W-1];
  assign ramSel   = cartSel & ramEn & inRamWin;

  AST_PRIM_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    primBank != '0); // R3
  AST_PRIM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldPrim |=> $stable(primBank)); // R8
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldSec |=> $stable(secBank)); // R8
  AST_GP_MODE0: assert property (@(posedge clk) disable iff (!rstN)
    !modeRam |-> (gpOut == '0)); // R6
  AST_TOP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr >= 16'hFE00) |-> (!romSel && !ramSel)); // R7
  AST_RAMSEL_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> ramEn); // R4
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuDataIn,
  input  logic                  wrStrobe,
  input  logic                  cartSel,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  romSel,
  output logic                  ramSel,
  output logic [SEC_W-1:0]      gpOut
);
  bankStrobe_t stb;

  bank_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddrHi (cpuAddr[ADDR_W-1:RAM_OFS_W]),
    .cpuDataIn (cpuDataIn),
    .wrStrobe  (wrStrobe),
    .cartSel   (cartSel),
    .stb       (stb)
  );

  bank_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cpuAddr (cpuAddr),
    .cartSel (cartSel),
    .stb     (stb),
    .romAddr (romAddr),
    .ramAddr (ramAddr),
    .romSel  (romSel),
    .ramSel  (ramSel),
    .gpOut   (gpOut)
  );
endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuDataIn = '0;
  logic        wrStrobe = 1'b0;
  logic        cartSel = 1'b0;
  logic [20:0] romAddr;
  logic [14:0] ramAddr;
  logic        romSel;
  logic        ramSel;
  logic [1:0]  gpOut;

  int nChecks = 0;
  int nFails  = 0;

  // reference state, kept from the requirements
  logic [4:0] mPrim = 5'd1;
  logic [1:0] mSec  = 2'd0;
  logic       mMode = 1'b0;
  logic       mRamEn = 1'b0;

  always #10 clk = ~clk;

  cart_bank_ctrl u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDataIn(cpuDataIn),
    .wrStrobe(wrStrobe), .cartSel(cartSel), .romAddr(romAddr),
    .ramAddr(ramAddr), .romSel(romSel), .ramSel(ramSel), .gpOut(gpOut)
  );

  // {wAddr, wData, probeAddr, expRamSel, expRomSel, expGp}
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {16'h2000, 8'h00, 16'h4123, 1'b0, 1'b1, 2'd0},
    {16'h3FFF, 8'h1F, 16'h7FFF, 1'b0, 1'b1, 2'd0},
    {16'h5000, 8'h03, 16'h4000, 1'b0, 1'b1, 2'd0},
    {16'h2000, 8'hE2, 16'h1234, 1'b0, 1'b1, 2'd0},
    {16'h0000, 8'h0A, 16'hA010, 1'b1, 1'b0, 2'd0},
    {16'h6000, 8'h01, 16'hB000, 1'b1, 1'b0, 2'd3},
    {16'h4000, 8'hFE, 16'h6000, 1'b0, 1'b1, 2'd2},
    {16'h1000, 8'h1B, 16'hA000, 1'b0, 1'b0, 2'd2},
    {16'h0FFF, 8'hFA, 16'hBFFF, 1'b1, 1'b0, 2'd2},
    {16'h7000, 8'h00, 16'hA000, 1'b1, 1'b0, 2'd0},
    {16'h2000, 8'h20, 16'h4000, 1'b0, 1'b1, 2'd0},
    {16'h8000, 8'hFF, 16'hFE00, 1'b0, 1'b0, 2'd0},
    {16'hFF00, 8'h01, 16'h4000, 1'b0, 1'b1, 2'd0},
    {16'hC000, 8'h00, 16'hFFFF, 1'b0, 1'b0, 2'd0}
  };

  function automatic logic [20:0] expRom(input logic [15:0] a);
    if (a[14]) return {(mMode ? 2'b00 : mSec), mPrim, a[13:0]}; // R2
    return {7'd0, a[13:0]};                                    // R1
  endfunction

  function automatic logic [14:0] expRam(input logic [15:0] a);
    return {(mMode ? mSec : 2'b00), a[12:0]}; // R6
  endfunction

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    if (!a[15]) begin
      case (a[14:13])
        2'b00: mRamEn = (d[3:0] == 4'hA);               // R4
        2'b01: mPrim  = (d[4:0] == 0) ? 5'd1 : d[4:0];  // R3
        2'b10: mSec   = d[1:0];                         // R5
        default: mMode = d[0];                          // R5
      endcase
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cpuAddr = a; cpuDataIn = d; cartSel = sel; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
    @(negedge clk);
    cartSel = 1'b1;
    if (sel) modelWrite(a, d);
  endtask

  task automatic probeAll(input string req, input logic [15:0] a);
    cpuAddr = a;
    #2;
    chk(req, "romAddr", 32'(romAddr), 32'(expRom(a)));
    chk(req, "ramAddr", 32'(ramAddr), 32'(expRam(a)));
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    cartSel = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    probeAll("R9", 16'h4000);
    chk("R9", "gpOut", 32'(gpOut), 0);
    cpuAddr = 16'hA000; #2;
    chk("R9", "ramSel", 32'(ramSel), 0);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      busWrite(v[43:28], v[27:20], 1'b1);
      probeAll("R1/R2/R3/R6", v[19:4]);
      chk("R4", "ramSel", 32'(ramSel), 32'(v[3]));
      chk("R7", "romSel", 32'(romSel), 32'(v[2]));
      chk("R6", "gpOut", 32'(gpOut), 32'(v[1:0]));
    end

    // R8: write with cartSel low leaves primary bank alone
    busWrite(16'h2000, 8'h05, 1'b0);
    probeAll("R8", 16'h4000);

    // R8: strobe held high while data changes loads only once
    @(negedge clk);
    cpuAddr = 16'h2000; cpuDataIn = 8'h03; wrStrobe = 1'b1;
    modelWrite(16'h2000, 8'h03);
    @(negedge clk);
    cpuDataIn = 8'h07;
    @(negedge clk);
    @(negedge clk);
    wrStrobe = 1'b0;
    @(negedge clk);
    probeAll("R8", 16'h4ABC);

    // R7: RAM window unselected while cartSel low
    cartSel = 1'b0; cpuAddr = 16'hA000; #2;
    chk("R7", "ramSel", 32'(ramSel), 0);
    chk("R7", "romSel", 32'(romSel), 0);
    cartSel = 1'b1;

    // R6: mode 1 with secondary 1 then reset clears everything (R9)
    busWrite(16'h6000, 8'h01, 1'b1);
    busWrite(16'h4000, 8'h01, 1'b1);
    probeAll("R6", 16'hA123);
    chk("R6", "gpOut", 32'(gpOut), 1);
    rstN = 1'b0;
    mPrim = 5'd1; mSec = 2'd0; mMode = 1'b0; mRamEn = 1'b0;
    #2;
    probeAll("R9", 16'h5555);
    chk("R9", "gpOut", 32'(gpOut), 0);
    cpuAddr = 16'hA000; #2;
    chk("R9", "ramSel", 32'(ramSel), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule